// File: doc/BRIEF.md
# Serial Flash Bitstream Read Responder

This block stands in for the read path of a small serial flash that holds a configuration bitstream for a loader. While chip select is low, it samples the serial data input on every rising serial clock. It first assembles a command byte. If the command is the read opcode, it then takes a 24-bit byte address. From that point it streams the stored bits out, one per clock, for as long as the clocks keep coming. A loader that ties the data input high still gets a valid read: all-ones is the read opcode, the all-ones address selects the top byte, and the stream then wraps to byte zero and carries on.

The array depth is set by a parameter, as a number of address bits. Only the low address bits of the 24-bit field are kept. A synchronous write-only backdoor port fills the array before a test.

Chip select is sampled on the serial clock. It must be seen high on at least one rising edge between transactions. The first rising edge with chip select low is the first command bit of a new transaction. The active-low reset is asynchronous and abandons any transaction that is under way.

Top module: `sfr_read_responder`

## Requirements
- R1: After reset, and whenever chip select is high, the data output is 0.
- R2: The command is the first 8 bits sampled after chip select goes low, taken most significant bit first. The value 0xFF starts a read.
- R3: A command other than 0xFF keeps the data output at 0 for every later clock, until chip select is seen high.
- R4: After a read command, the next 24 sampled bits form the address, most significant bit first. Only the low ARR_ABITS bits select the byte.
- R5: Once the 32nd header bit is sampled, and before the next rising edge, the data output shows bit 7 of the addressed byte. Each further rising edge moves on to the next lower bit.
- R6: After the 8th bit of a byte, the address advances by one. The top address wraps to 0.
- R7: If the data input is held at 1 for the whole header, the read starts at the top byte of the array, then continues with byte 0 and byte 1.
- R8: A read has no length limit. It keeps streaming through more than a full pass of the array.
- R9: A low reset forces the data output to 0 at once and abandons the transaction. After release, with chip select still low, the next 32 bits are decoded as a fresh header.
- R10: When chip select is seen high mid-byte, the data output drops to 0. The next transaction starts with a new header, and its first output bit is bit 7 of its own byte.
- R11: A backdoor write with `bd_we` high stores `bd_data` at `bd_addr` on the rising edge. Later reads return the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all sampling and storage happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial command/address input |
| dout | output | 1 | Serial read data, 0 when no read is active |
| bd_we | input | 1 | Backdoor write enable |
| bd_addr | input | ARR_ABITS | Backdoor byte address |
| bd_data | input | 8 | Backdoor byte value |

## Verification
Reads are run with several header patterns, and each one tells different faults apart:
- A plain small address shows the MSB-first order and the one-cycle output alignment.
- An address with bits set above the array width shows that only the low bits are kept.
- An all-ones header shows both the top-address start and the wrap to zero.

Near-miss commands (0x7F, 0xFE, 0x03) separate an exact opcode match from a partial match. A read longer than the whole array separates an endless stream from one that stops after a fixed length. Chip select dropping mid-byte and reset pulsed mid-read both show whether the next header is taken cleanly from its first bit.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  // Transaction phases.
  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ADR  = 2'd1,
    PH_RD   = 2'd2,
    PH_SKIP = 2'd3
  } phase_t;

  localparam int          OPC_W    = 8;
  localparam int          ADF_W    = 24;
  localparam int          HDR_BITS = OPC_W + ADF_W;
  localparam logic [7:0]  OPC_READ = 8'hFF;

  function automatic logic opc_is_read(input logic [7:0] c);
    return c == OPC_READ;
  endfunction

  // Bit idx 0 is the most significant bit of the byte.
  function automatic logic pick_msb_first(input logic [7:0] b, input logic [2:0] idx);
    return b[3'd7 - idx];
  endfunction
endpackage

// File: rtl/sfr_store.sv
module sfr_store #(
  parameter int ABITS = 10
) (
  input  logic             sclk,
  input  logic             bd_we,
  input  logic [ABITS-1:0] bd_addr,
  input  logic [7:0]       bd_data,
  input  logic [ABITS-1:0] rd_addr,
  output logic [7:0]       rd_byte
);
  localparam int DEPTH = 1 << ABITS;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge sclk) begin
    if (bd_we) mem[bd_addr] <= bd_data;
  end

  assign rd_byte = mem[rd_addr];
endmodule

// File: rtl/sfr_seq.sv
module sfr_seq
  import sfr_pkg::*;
#(
  parameter int ABITS = 10
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             din,
  output phase_t           phase,
  output logic [ABITS-1:0] rd_addr,
  output logic [2:0]       bit_idx,
  output logic             ev_cmd_miss,
  output logic             ev_byte_end
);
  localparam int HC_W = $clog2(ADF_W);

  logic [HC_W-1:0]  hcnt;
  logic [OPC_W-2:0] cmd_sh;
  logic [ABITS-2:0] adr_sh;
  logic [OPC_W-1:0] cmd_nxt;
  logic [ABITS-1:0] adr_nxt;
  logic             cmd_last, adr_last;

  assign cmd_nxt  = {cmd_sh, din};
  assign adr_nxt  = {adr_sh, din};
  assign cmd_last = hcnt == HC_W'(OPC_W - 1);
  assign adr_last = hcnt == HC_W'(ADF_W - 1);

  assign ev_cmd_miss = !cs_n && phase == PH_CMD && cmd_last && !opc_is_read(cmd_nxt);
  assign ev_byte_end = !cs_n && phase == PH_RD && bit_idx == 3'd7;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_CMD;
      hcnt    <= '0;
      cmd_sh  <= '0;
      adr_sh  <= '0;
      rd_addr <= '0;
      bit_idx <= '0;
    end else if (cs_n) begin
      phase   <= PH_CMD;
      hcnt    <= '0;
      bit_idx <= '0;
    end else begin
      unique case (phase)
        PH_CMD: begin
          cmd_sh <= cmd_nxt[OPC_W-2:0];
          if (cmd_last) begin
            hcnt  <= '0;
            phase <= opc_is_read(cmd_nxt) ? PH_ADR : PH_SKIP;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        PH_ADR: begin
          adr_sh <= adr_nxt[ABITS-2:0];
          if (adr_last) begin
            hcnt    <= '0;
            rd_addr <= adr_nxt;
            bit_idx <= '0;
            phase   <= PH_RD;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        PH_RD: begin
          bit_idx <= bit_idx + 1'b1;
          if (bit_idx == 3'd7) rd_addr <= rd_addr + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sfr_out.sv
module sfr_out
  import sfr_pkg::*;
(
  input  phase_t     phase,
  input  logic       cs_n,
  input  logic [7:0] rd_byte,
  input  logic [2:0] bit_idx,
  output logic       dout
);
  logic rd_live;

  assign rd_live = !cs_n && phase == PH_RD;
  assign dout    = rd_live ? pick_msb_first(rd_byte, bit_idx) : 1'b0;
endmodule

// File: rtl/sfr_read_responder.sv
module sfr_read_responder
  import sfr_pkg::*;
#(
  parameter int ARR_ABITS = 10
) (
  input  logic                 sclk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 din,
  output logic                 dout,
  input  logic                 bd_we,
  input  logic [ARR_ABITS-1:0] bd_addr,
  input  logic [7:0]           bd_data
);
  phase_t               phase;
  logic [ARR_ABITS-1:0] rd_addr;
  logic [2:0]           bit_idx;
  logic [7:0]           rd_byte;
  logic                 ev_cmd_miss;
  logic                 ev_byte_end;

  sfr_seq #(.ABITS(ARR_ABITS)) u_seq (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .din(din),
    .phase(phase), .rd_addr(rd_addr), .bit_idx(bit_idx),
    .ev_cmd_miss(ev_cmd_miss), .ev_byte_end(ev_byte_end)
  );

  sfr_store #(.ABITS(ARR_ABITS)) u_store (
    .sclk(sclk), .bd_we(bd_we), .bd_addr(bd_addr), .bd_data(bd_data),
    .rd_addr(rd_addr), .rd_byte(rd_byte)
  );

  sfr_out u_out (
    .phase(phase), .cs_n(cs_n), .rd_byte(rd_byte), .bit_idx(bit_idx), .dout(dout)
  );
endmodule

// File: rtl/sfr_read_responder_chk.sv
module sfr_read_responder_chk
  import sfr_pkg::*;
#(
  parameter int ARR_ABITS = 10
) (
  input logic                 sclk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 dout,
  input phase_t               phase,
  input logic [ARR_ABITS-1:0] rd_addr,
  input logic [2:0]           bit_idx,
  input logic                 ev_cmd_miss,
  input logic                 ev_byte_end
);
  localparam logic [ARR_ABITS-1:0] ONE = ARR_ABITS'(1);

  // Edges seen with chip select low since it was last high (saturating).
  logic [5:0] low_cnt;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)                low_cnt <= '0;
    else if (cs_n)             low_cnt <= '0;
    else if (low_cnt != 6'h3F) low_cnt <= low_cnt + 1'b1;
  end

  p_idle_zero_r1: assert property (@(posedge sclk) disable iff (!rst_n)
    cs_n |-> !dout);

  p_miss_enter_r3: assert property (@(posedge sclk) disable iff (!rst_n)
    ev_cmd_miss |=> phase == PH_SKIP);

  p_skip_hold_r3: assert property (@(posedge sclk) disable iff (!rst_n)
    (phase == PH_SKIP && !cs_n) |=> (phase == PH_SKIP && !dout));

  p_hdr_len_r4: assert property (@(posedge sclk) disable iff (!rst_n)
    (phase == PH_RD) |-> (low_cnt >= 6'(HDR_BITS)));

  p_bit_step_r5: assert property (@(posedge sclk) disable iff (!rst_n)
    (phase == PH_RD && !cs_n) |=> (phase == PH_RD && bit_idx == $past(bit_idx) + 3'd1));

  p_addr_step_r6: assert property (@(posedge sclk) disable iff (!rst_n)
    ev_byte_end |=> rd_addr == $past(rd_addr) + ONE);

  p_abort_r9: assert property (@(posedge sclk)
    !rst_n |-> (!dout && phase == PH_CMD));
endmodule

bind sfr_read_responder sfr_read_responder_chk #(.ARR_ABITS(ARR_ABITS)) u_chk (
  .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .dout(dout),
  .phase(phase), .rd_addr(rd_addr), .bit_idx(bit_idx),
  .ev_cmd_miss(ev_cmd_miss), .ev_byte_end(ev_byte_end)
);

// File: tb/sfr_read_responder_tb.sv
module sfr_read_responder_tb;
  localparam int CLK_P = 10;
  localparam int AB    = 10;
  localparam int DEPTH = 1 << AB;

  logic          sclk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          din = 1'b0;
  logic          dout;
  logic          bd_we = 1'b0;
  logic [AB-1:0] bd_addr = '0;
  logic [7:0]    bd_data = '0;

  int checks = 0;
  int errors = 0;
  logic [7:0] ref_mem [DEPTH];

  always #(CLK_P/2) sclk = ~sclk;

  sfr_read_responder #(.ARR_ABITS(AB)) u_dut (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .din(din), .dout(dout),
    .bd_we(bd_we), .bd_addr(bd_addr), .bd_data(bd_data)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) ^ (a >> 3));
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive_bit(input logic b);
    @(negedge sclk);
    rst_n = 1'b1;
    cs_n  = 1'b0;
    din   = b;
  endtask

  task automatic send_header(input logic [7:0] cmd, input logic [23:0] adr);
    for (int i = 7; i >= 0; i--) drive_bit(cmd[i]);
    for (int i = 23; i >= 0; i--) drive_bit(adr[i]);
  endtask

  task automatic read_byte(input int a, input string tag);
    logic [7:0] e;
    e = ref_mem[a % DEPTH];
    for (int i = 7; i >= 0; i--) begin
      @(negedge sclk);
      din = 1'b0;
      #1;
      chk(dout === e[i], tag, int'(dout), int'(e[i]));
    end
  endtask

  task automatic end_txn();
    @(negedge sclk);
    cs_n = 1'b1;
    din  = 1'b0;
  endtask

  task automatic bd_write(input int a, input logic [7:0] v);
    @(negedge sclk);
    bd_we = 1'b1; bd_addr = AB'(a); bd_data = v;
    ref_mem[a] = v;
    @(negedge sclk);
    bd_we = 1'b0;
  endtask

  // R1: output quiet in reset and with chip select high
  task automatic t_reset();
    repeat (3) @(negedge sclk);
    #1 chk(dout === 1'b0, "R1 reset", int'(dout), 0);
    @(negedge sclk);
    rst_n = 1'b1;
    #1 chk(dout === 1'b0, "R1 cs high", int'(dout), 0);
  endtask

  task automatic t_preload();
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge sclk);
      bd_we = 1'b1; bd_addr = AB'(a); bd_data = pat(a);
      ref_mem[a] = pat(a);
    end
    @(negedge sclk);
    bd_we = 1'b0;
  endtask

  // R2 R4 R5 R6: plain read across a few bytes
  task automatic t_plain();
    send_header(8'hFF, 24'h000010);
    for (int k = 0; k < 3; k++) read_byte(16 + k, "R2/R5/R6 plain");
    end_txn();
  endtask

  // R4: high address bits are dropped
  task automatic t_high_bits();
    send_header(8'hFF, 24'hABC123);
    read_byte(32'h123, "R4 low bits");
    read_byte(32'h124, "R4 next");
    end_txn();
  endtask

  // R7: data input held high through the header
  task automatic t_all_ones();
    for (int i = 0; i < 32; i++) drive_bit(1'b1);
    read_byte(DEPTH - 1, "R7 top");
    read_byte(0, "R7 wrap0");
    read_byte(1, "R7 wrap1");
    end_txn();
  endtask

  // R3: commands other than 0xFF leave the output quiet
  task automatic t_bad_cmd(input logic [7:0] c);
    int ones;
    ones = 0;
    send_header(c, 24'h000000);
    for (int i = 0; i < 24; i++) begin
      @(negedge sclk);
      din = 1'b1;
      #1;
      if (dout !== 1'b0) ones++;
    end
    chk(ones == 0, "R3 bad cmd", ones, 0);
    end_txn();
  endtask

  // R8 R6: read beyond a full pass of the array
  task automatic t_long();
    send_header(8'hFF, 24'(DEPTH - 16));
    for (int k = 0; k < DEPTH + 32; k++) read_byte(DEPTH - 16 + k, "R8 long");
    end_txn();
  endtask

  // R10: chip select high mid-byte, then a fresh transaction
  task automatic t_cs_abort();
    logic [7:0] e;
    e = ref_mem[32'h20];
    send_header(8'hFF, 24'h000020);
    for (int i = 7; i >= 5; i--) begin
      @(negedge sclk);
      #1 chk(dout === e[i], "R10 partial", int'(dout), int'(e[i]));
    end
    end_txn();
    #1 chk(dout === 1'b0, "R10 cs high", int'(dout), 0);
    send_header(8'hFF, 24'h000100);
    read_byte(32'h100, "R10 fresh");
    end_txn();
  endtask

  // R9: reset mid-read, header resumes while chip select stays low
  task automatic t_rst_abort();
    send_header(8'hFF, 24'h000040);
    read_byte(32'h40, "R9 pre");
    @(negedge sclk);
    rst_n = 1'b0;
    #1 chk(dout === 1'b0, "R9 in reset", int'(dout), 0);
    send_header(8'hFF, 24'h000200);
    read_byte(32'h200, "R9 after");
    end_txn();
  endtask

  // R11: backdoor overwrite seen by a later read
  task automatic t_backdoor();
    bd_write(32'h55, 8'hA5);
    bd_write(32'h56, 8'h3C);
    send_header(8'hFF, 24'h000055);
    read_byte(32'h55, "R11 bd0");
    read_byte(32'h56, "R11 bd1");
    end_txn();
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_preload();
    t_plain();
    t_high_bits();
    t_all_ones();
    t_bad_cmd(8'h03);
    t_bad_cmd(8'h7F);
    t_bad_cmd(8'hFE);
    t_long();
    t_cs_abort();
    t_rst_abort();
    t_backdoor();
    repeat (2) @(negedge sclk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule